// File: doc/BRIEF.md
# DMA Page Register and Transfer Address Generator

This block keeps the page bytes that extend a four-channel DMA controller's 16-bit channel addresses into a full physical address. Each channel has a low page byte and, when the high bank is built in, a high page byte. Software reaches both banks through byte-wide ports selected by a 3-bit port offset and a bank select. The offsets map to channels in a fixed order with gaps, and the unused offsets do nothing.

When a transfer starts, the controller presents the channel, its mode byte and its 16-bit start address on a load strobe. The block takes a copy of that channel's page bytes and drives a registered 31-bit physical address. Each beat strobe then moves the low 16 bits by one step, up or down as the mode byte selects, until a stop strobe ends the run.

Top module: `dmapg_top`

## Requirements
- R1: Port offset 3'd1 selects channel 2, 3'd2 selects channel 3, 3'd3 selects channel 1 and 3'd7 selects channel 0. A write with `portWr` high stores `portWData` in the selected channel's low page (`hiBank`=0) or high page (`hiBank`=1). The change is visible from the next cycle.
- R2: Offsets 3'd0, 3'd4, 3'd5 and 3'd6 select no channel. Writes to them change no page byte, and reads from them return 8'h00.
- R3: While `portRd` is high on a mapped offset, `rdData` shows the stored byte in the same cycle. While `portRd` is low, `rdData` is 8'h00.
- R4: One cycle after `runLoad`, `physAddr` is {high page bits 6:0, low page, `runStart`} of channel `runChan`, using the page values held before that edge. Page writes made later do not alter a running address.
- R5: When `runMode` bit 5 is 0 at load, each beat (`runBeat` high while active, with no load or stop in the same cycle) raises `physAddr[15:0]` by one. After p beats it equals start plus p.
- R6: When `runMode` bit 5 is 1 at load, each beat lowers `physAddr[15:0]` by one. After p beats it equals start minus p.
- R7: Stepping wraps modulo 2^16 and never changes `physAddr[30:16]`.
- R8: `xferActive` rises one cycle after `runLoad` and falls one cycle after `runStop`. Load takes priority over stop. Beats while inactive, or in a stop cycle, leave `physAddr` unchanged.
- R9: With `HAS_HIGH_PAGE`=0, high bank writes are ignored, high bank reads return 8'h00, and `physAddr[30:24]` stays 0.
- R10: After reset all page bytes, `physAddr` and `xferActive` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hiBank | input | 1 | Port access targets the high page bank |
| portOff | input | 3 | Port offset |
| portWr | input | 1 | Page write strobe |
| portRd | input | 1 | Page read strobe |
| portWData | input | 8 | Page write data |
| rdData | output | 8 | Page read data, combinational |
| runLoad | input | 1 | Start a transfer |
| runChan | input | 2 | Channel of the transfer |
| runMode | input | 8 | Channel mode byte, bit 5 selects decrement |
| runStart | input | 16 | Start channel address |
| runBeat | input | 1 | Transfer beat strobe |
| runStop | input | 1 | End the transfer |
| physAddr | output | 31 | Registered physical address |
| xferActive | output | 1 | Transfer in progress |

## Verification
The properties assume that the strobes are clean single-cycle levels sampled at the rising edge. They also assume that `runStart` and `runMode` only matter in a cycle where `runLoad` is high, so the checker keeps its own copy of the direction taken at load. The stimulus drives every input at the falling edge. It mixes loads, beats and stops with page writes in the same cycles, and it lets load and stop collide. Directed runs force the 16-bit wrap in both directions and touch every unmapped offset.

// File: rtl/dmapg_pkg.sv
package dmapg_pkg;
  localparam int CHAN_N = 4;
  localparam int CHAN_W = $clog2(CHAN_N);

  typedef struct packed {
    logic              pageWe;
    logic              hiWe;
    logic [CHAN_W-1:0] wrChan;
    logic              load;
    logic              step;
    logic              down;
  } dpCtrl_t;

  // Port offset to channel: 1->2, 2->3, 3->1, 7->0; others unmapped.
  function automatic logic [CHAN_W:0] decodeOff(input logic [2:0] off);
    case (off)
      3'd1:    decodeOff = {1'b1, 2'd2};
      3'd2:    decodeOff = {1'b1, 2'd3};
      3'd3:    decodeOff = {1'b1, 2'd1};
      3'd7:    decodeOff = {1'b1, 2'd0};
      default: decodeOff = '0;
    endcase
  endfunction
endpackage

// File: rtl/dmapg_ctrl.sv
module dmapg_ctrl
  import dmapg_pkg::*;
#(
  parameter bit HAS_HIGH_PAGE = 1'b1,
  parameter int MODE_W = 8,
  parameter int DIR_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiBank,
  input  logic [2:0]        portOff,
  input  logic              portWr,
  input  logic              portRd,
  input  logic              runLoad,
  input  logic [MODE_W-1:0] runMode,
  input  logic              runBeat,
  input  logic              runStop,
  output dpCtrl_t           strobes,
  output logic [CHAN_W-1:0] rdChan,
  output logic              rdHit,
  output logic              rdHigh,
  output logic              active
);
  logic [CHAN_W:0] dec;
  logic            mapped;
  logic            bankOk;
  logic            downQ;

  assign dec    = decodeOff(portOff);
  assign mapped = dec[CHAN_W];
  assign bankOk = !hiBank || HAS_HIGH_PAGE;

  assign rdChan = dec[CHAN_W-1:0];
  assign rdHit  = portRd && mapped && bankOk;
  assign rdHigh = hiBank;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      downQ  <= 1'b0;
    end else if (runLoad) begin
      active <= 1'b1;
      downQ  <= runMode[DIR_BIT];
    end else if (runStop) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    strobes.pageWe = portWr && mapped && !hiBank;
    strobes.hiWe   = portWr && mapped && hiBank && HAS_HIGH_PAGE;
    strobes.wrChan = dec[CHAN_W-1:0];
    strobes.load   = runLoad;
    strobes.step   = runBeat && active && !runLoad && !runStop;
    strobes.down   = downQ;
  end
endmodule

// File: rtl/dmapg_datapath.sv
module dmapg_datapath
  import dmapg_pkg::*;
#(
  parameter bit HAS_HIGH_PAGE = 1'b1,
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int HI_USE_W = 7,
  localparam int PHYS_W = HI_USE_W + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic [PAGE_W-1:0] wrData,
  input  logic [CHAN_W-1:0] rdChan,
  input  logic              rdHit,
  input  logic              rdHigh,
  input  logic [CHAN_W-1:0] runChan,
  input  logic [ADDR_W-1:0] runStart,
  output logic [PAGE_W-1:0] rdData,
  output logic [PHYS_W-1:0] physAddr
);
  logic [PAGE_W-1:0] pageQ [CHAN_N];
  logic [PAGE_W-1:0] hiQ   [CHAN_N];
  logic [ADDR_W-1:0] curAddr;

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pageQ[c] <= '0;
      else if (strobes.pageWe && strobes.wrChan == CHAN_W'(c)) pageQ[c] <= wrData;
    end
    if (HAS_HIGH_PAGE) begin : g_hi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) hiQ[c] <= '0;
        else if (strobes.hiWe && strobes.wrChan == CHAN_W'(c)) hiQ[c] <= wrData;
      end
    end else begin : g_nohi
      assign hiQ[c] = '0;
    end
  end

  assign rdData = !rdHit ? '0 : (rdHigh ? hiQ[rdChan] : pageQ[rdChan]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr <= '0;
    end else if (strobes.load) begin
      physAddr <= {hiQ[runChan][HI_USE_W-1:0], pageQ[runChan], runStart};
    end else if (strobes.step) begin
      physAddr[ADDR_W-1:0] <= strobes.down ? curAddr - 1'b1 : curAddr + 1'b1;
    end
  end

  assign curAddr = physAddr[ADDR_W-1:0];
endmodule

// File: rtl/dmapg_top.sv
module dmapg_top
  import dmapg_pkg::*;
#(
  parameter bit HAS_HIGH_PAGE = 1'b1,
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int HI_USE_W = 7,
  parameter int MODE_W = 8,
  parameter int DIR_BIT = 5,
  localparam int PHYS_W = HI_USE_W + PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hiBank,
  input  logic [2:0]        portOff,
  input  logic              portWr,
  input  logic              portRd,
  input  logic [PAGE_W-1:0] portWData,
  output logic [PAGE_W-1:0] rdData,
  input  logic              runLoad,
  input  logic [CHAN_W-1:0] runChan,
  input  logic [MODE_W-1:0] runMode,
  input  logic [ADDR_W-1:0] runStart,
  input  logic              runBeat,
  input  logic              runStop,
  output logic [PHYS_W-1:0] physAddr,
  output logic              xferActive
);
  dpCtrl_t           strobes;
  logic [CHAN_W-1:0] rdChan;
  logic              rdHit;
  logic              rdHigh;

  dmapg_ctrl #(.HAS_HIGH_PAGE(HAS_HIGH_PAGE), .MODE_W(MODE_W), .DIR_BIT(DIR_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .hiBank(hiBank), .portOff(portOff), .portWr(portWr),
    .portRd(portRd), .runLoad(runLoad), .runMode(runMode), .runBeat(runBeat),
    .runStop(runStop), .strobes(strobes), .rdChan(rdChan), .rdHit(rdHit),
    .rdHigh(rdHigh), .active(xferActive)
  );

  dmapg_datapath #(.HAS_HIGH_PAGE(HAS_HIGH_PAGE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
                   .HI_USE_W(HI_USE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(portWData), .rdChan(rdChan),
    .rdHit(rdHit), .rdHigh(rdHigh), .runChan(runChan), .runStart(runStart),
    .rdData(rdData), .physAddr(physAddr)
  );
endmodule

// File: rtl/dmapg_checker.sv
module dmapg_checker #(
  parameter bit HAS_HIGH_PAGE = 1'b1,
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int PHYS_W = 31,
  parameter int MODE_W = 8,
  parameter int DIR_BIT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        portOff,
  input logic              portRd,
  input logic [PAGE_W-1:0] rdData,
  input logic              runLoad,
  input logic [MODE_W-1:0] runMode,
  input logic [ADDR_W-1:0] runStart,
  input logic              runBeat,
  input logic              runStop,
  input logic [PHYS_W-1:0] physAddr,
  input logic              xferActive
);
  logic dirDown;
  logic unmapped;
  logic stepNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirDown <= 1'b0;
    else if (runLoad) dirDown <= runMode[DIR_BIT];
  end

  assign unmapped = (portOff == 3'd0) || (portOff == 3'd4) || (portOff == 3'd5) || (portOff == 3'd6);
  assign stepNow  = runBeat && xferActive && !runLoad && !runStop;

  a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (portRd && unmapped) |-> (rdData == '0));
  a_r3_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !portRd |-> (rdData == '0));
  a_r4_load_start: assert property (@(posedge clk) disable iff (!rstN)
    runLoad |=> (physAddr[ADDR_W-1:0] == $past(runStart)));
  a_r5_step_up: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && !dirDown) |=> (physAddr[ADDR_W-1:0] == $past(physAddr[ADDR_W-1:0]) + 1'b1));
  a_r6_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (stepNow && dirDown) |=> (physAddr[ADDR_W-1:0] == $past(physAddr[ADDR_W-1:0]) - 1'b1));
  a_r7_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    !runLoad |=> $stable(physAddr[PHYS_W-1:ADDR_W]));
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!runLoad && !stepNow) |=> $stable(physAddr));
  a_r8_active_on_load: assert property (@(posedge clk) disable iff (!rstN)
    runLoad |=> xferActive);
  a_r8_inactive_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    (runStop && !runLoad) |=> !xferActive);
  a_r9_no_high_bits: assert property (@(posedge clk) disable iff (!rstN)
    !HAS_HIGH_PAGE |-> (physAddr[PHYS_W-1:PHYS_W-7] == '0));
endmodule

bind dmapg_top dmapg_checker #(
  .HAS_HIGH_PAGE(HAS_HIGH_PAGE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PHYS_W(PHYS_W),
  .MODE_W(MODE_W), .DIR_BIT(DIR_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .portOff(portOff), .portRd(portRd), .rdData(rdData),
  .runLoad(runLoad), .runMode(runMode), .runStart(runStart), .runBeat(runBeat),
  .runStop(runStop), .physAddr(physAddr), .xferActive(xferActive)
);

// File: tb/sim_dmapg_top.sv
module sim_dmapg_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hiBank = 1'b0;
  logic [2:0]  portOff = '0;
  logic        portWr = 1'b0;
  logic        portRd = 1'b0;
  logic [7:0]  portWData = '0;
  logic        runLoad = 1'b0;
  logic [1:0]  runChan = '0;
  logic [7:0]  runMode = '0;
  logic [15:0] runStart = '0;
  logic        runBeat = 1'b0;
  logic        runStop = 1'b0;
  logic [7:0]  rdData0, rdData1;
  logic [30:0] phys0, phys1;
  logic        act0, act1;

  int nVec = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [7:0]  pgM [4];
  logic [7:0]  hiM [4];
  logic [14:0] snap0, snap1;
  logic [15:0] curM;
  logic        actM, downM;

  always #2.5 clk = ~clk;

  dmapg_top u0 (
    .clk(clk), .rstN(rstN), .hiBank(hiBank), .portOff(portOff), .portWr(portWr),
    .portRd(portRd), .portWData(portWData), .rdData(rdData0), .runLoad(runLoad),
    .runChan(runChan), .runMode(runMode), .runStart(runStart), .runBeat(runBeat),
    .runStop(runStop), .physAddr(phys0), .xferActive(act0)
  );

  dmapg_top #(.HAS_HIGH_PAGE(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .hiBank(hiBank), .portOff(portOff), .portWr(portWr),
    .portRd(portRd), .portWData(portWData), .rdData(rdData1), .runLoad(runLoad),
    .runChan(runChan), .runMode(runMode), .runStart(runStart), .runBeat(runBeat),
    .runStop(runStop), .physAddr(phys1), .xferActive(act1)
  );

  function automatic int chanOf(input logic [2:0] off);
    case (off)
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 1;
      3'd7: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] expRead(input bit withHigh);
    int ch;
    ch = chanOf(portOff);
    if (!portRd || ch < 0) return 8'h00;
    if (hiBank) return withHigh ? hiM[ch] : 8'h00;
    return pgM[ch];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkReads(input string req);
    check(req, {24'd0, rdData0}, {24'd0, expRead(1'b1)});
    check({req, "/R9"}, {24'd0, rdData1}, {24'd0, expRead(1'b0)});
  endtask

  task automatic checkAddr(input string req);
    check(req, {1'b0, phys0}, {1'b0, snap0, curM});
    check({req, "/R9"}, {1'b0, phys1}, {9'd0, snap1[7:0], curM});
    check({req, " active"}, {31'd0, act0}, {31'd0, actM});
  endtask

  // One clock edge with the inputs already driven; update the model, then check.
  task automatic step(input string req);
    int ch;
    @(posedge clk);
    ch = chanOf(portOff);
    if (runLoad) begin
      actM  = 1'b1;
      downM = runMode[5];
      curM  = runStart;
      snap0 = {hiM[runChan][6:0], pgM[runChan]};
      snap1 = {7'd0, pgM[runChan]};
    end else if (runStop) begin
      actM = 1'b0;
    end else if (runBeat && actM) begin
      curM = downM ? curM - 16'd1 : curM + 16'd1;
    end
    if (portWr && ch >= 0) begin
      if (hiBank) hiM[ch] = portWData;
      else pgM[ch] = portWData;
    end
    #1;
    checkAddr(req);
    @(negedge clk);
    {portWr, portRd, runLoad, runBeat, runStop} = '0;
  endtask

  task automatic wrPage(input bit hi, input logic [2:0] off, input logic [7:0] d);
    hiBank = hi; portOff = off; portWData = d; portWr = 1'b1;
    step("R1");
  endtask

  task automatic rdPage(input bit hi, input logic [2:0] off, input string req);
    hiBank = hi; portOff = off; portRd = 1'b1;
    #1;
    checkReads(req);
    step(req);
  endtask

  task automatic loadRun(input logic [1:0] ch, input bit dn, input logic [15:0] st);
    runLoad = 1'b1; runChan = ch; runMode = {2'b01, dn, 5'b00110}; runStart = st;
    step("R4");
  endtask

  task automatic beats(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      runBeat = 1'b1;
      step(req);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nFail++;
      nVec++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin pgM[c] = '0; hiM[c] = '0; end
    snap0 = '0; snap1 = '0; curM = '0; actM = 1'b0; downM = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 phys", {1'b0, phys0}, 32'd0);
    check("R10 active", {31'd0, act0}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 8; o++) rdPage(1'b0, 3'(o), "R10");

    // R1 mapping: distinct bytes per channel in both banks
    wrPage(1'b0, 3'd1, 8'hA2); wrPage(1'b0, 3'd2, 8'hA3);
    wrPage(1'b0, 3'd3, 8'hA1); wrPage(1'b0, 3'd7, 8'hA0);
    wrPage(1'b1, 3'd1, 8'hD2); wrPage(1'b1, 3'd2, 8'hF3);
    wrPage(1'b1, 3'd3, 8'h91); wrPage(1'b1, 3'd7, 8'h80);
    // R2 unmapped writes
    wrPage(1'b0, 3'd0, 8'h11); wrPage(1'b1, 3'd4, 8'h22);
    wrPage(1'b0, 3'd5, 8'h33); wrPage(1'b1, 3'd6, 8'h44);
    for (int o = 0; o < 8; o++) begin
      rdPage(1'b0, 3'(o), "R1/R2");
      rdPage(1'b1, 3'(o), "R1/R2");
    end
    portRd = 1'b0; portOff = 3'd1; #1; checkReads("R3"); step("R3");

    // R5 increment with wrap, R7
    loadRun(2'd1, 1'b0, 16'hFFFD);
    beats(5, "R5/R7");
    // R4 page write mid-run does not move address
    wrPage(1'b0, 3'd3, 8'h5C);
    beats(1, "R4");
    // R6 decrement with wrap
    loadRun(2'd0, 1'b1, 16'h0002);
    beats(4, "R6/R7");
    // R8 stop, beats ignored after stop, stop with beat
    runStop = 1'b1; runBeat = 1'b1; step("R8");
    beats(3, "R8");
    // R8 load beats stop
    runLoad = 1'b1; runStop = 1'b1; runBeat = 1'b1; runChan = 2'd3; runMode = 8'h00;
    runStart = 16'h1234; step("R8");
    beats(2, "R5");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      hiBank    = 1'($urandom_range(0, 1));
      portOff   = 3'($urandom_range(0, 7));
      portWData = 8'($urandom);
      portWr    = ($urandom_range(0, 3) == 0);
      portRd    = ($urandom_range(0, 1) == 0);
      runLoad   = ($urandom_range(0, 15) == 0);
      runChan   = 2'($urandom_range(0, 3));
      runMode   = 8'($urandom);
      runStart  = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      runBeat   = ($urandom_range(0, 2) != 0);
      runStop   = ($urandom_range(0, 31) == 0);
      #1;
      checkReads("R3 rand");
      step("R5/R6 rand");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial void'($urandom(32'h5EED_0042));
endmodule